// File: doc/BRIEF.md
# Interrupt Line Synchronizer and Request Capture

This block sits in front of an interrupt priority controller. It takes a vector of asynchronous interrupt request lines, brings each one into the controller clock through a short flip-flop chain, and records it in a per-channel request register. Each channel is set to capture either a rising edge or a high level. An edge-captured request stays set until the controller core clears it on acknowledge. A level-captured request follows the synchronized line.

A separate debug-acknowledge line from a foreign clock domain passes through a chain of the same kind. Once synchronized, it masks the global interrupt enable. The block exports the request register, the synchronized debug line and the effective global enable. Priority resolution and bus access belong to the surrounding controller.

Top module: `irq_capture`

## Requirements
- R1: Each interrupt line passes through SYNC_STAGES (default 2) flip-flops. With the default, a line change made before clock edge k shows in `irq_req_o` after edge k+2, in either trigger mode.
- R2: `dbg_ack_async_i` passes through SYNC_STAGES flip-flops, so with the default a change made before edge k shows on `dbg_ack_sync_o` after edge k+1.
- R3: In edge mode a request bit is set only when the synchronized line was low in one cycle and high in the next. A line that is held high does not set the bit again after a clear.
- R4: In edge mode a set request bit stays set until that channel's `ack_clr_i` bit is asserted, whatever the line does.
- R5: When `ack_clr_i[i]` is high in a cycle, `irq_req_o[i]` is 0 after the next edge. This holds in both modes and wins over a simultaneous edge or high level.
- R6: In level mode (active-high), `irq_req_o[i]` after an edge equals the synchronized line as it stood before that edge, provided no clear is asserted.
- R7: `glob_en_eff_o` is high exactly when `glob_en_i` is high and `dbg_ack_sync_o` is low.
- R8: When `rst_n` is low at a clock edge, all request bits, synchronizer flops, edge history and `dbg_ack_sync_o` go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller operating clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_async_i | input | NUM_CH | Asynchronous interrupt request lines, active high |
| trig_edge_i | input | NUM_CH | Per-channel trigger mode: 1 = rising edge, 0 = high level |
| ack_clr_i | input | NUM_CH | Per-channel clear of the request bit, from the controller's acknowledge path |
| glob_en_i | input | 1 | Global interrupt enable from the controller |
| dbg_ack_async_i | input | 1 | Asynchronous debug-acknowledge line |
| irq_req_o | output | NUM_CH | Request register contents |
| dbg_ack_sync_o | output | 1 | Synchronized debug-acknowledge |
| glob_en_eff_o | output | 1 | Global enable after debug masking |

## Verification
On every cycle, the assertions check the following: the debug line's synchronizer latency, that a clear always wins, that an edge-mode bit holds until cleared, that an edge-mode bit rises only after a synchronized rising edge, that level-mode bits track the synchronized line, and the reset state. The bench covers what the assertions cannot show from port values alone. It measures the end-to-end latency from a raw line change to the request bit. It shows that a line held high after a clear does not re-arm an edge channel. It also sweeps every per-channel mix of edge and level modes against an independent cycle model, with pseudo-random lines, clears and debug toggles.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;

   typedef enum logic {
      TRIG_LEVEL = 1'b0,
      TRIG_RISE  = 1'b1
   } trig_e;

   localparam int SYNC_MIN = 2;
   localparam int SYNC_MAX = 4;
   localparam int CH_MAX   = 1024;

endpackage

// File: rtl/irq_sync_chain.sv
module irq_sync_chain #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync_chain: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("irq_sync_chain: WIDTH must be at least 1");
   end

   // stage 0 samples the raw line; stage LAST is the usable output
   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_async};
      end
   end

   assign q_sync = chain_q[LAST];

endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic prev,
   output logic rise
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev <= 1'b0;
      end else begin
         prev <= lvl;
      end
   end

   assign rise = lvl & ~prev;

endmodule

// File: rtl/irq_req_bit.sv
module irq_req_bit
   import irq_cap_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  trig_e trig,
   input  logic  lvl,
   input  logic  rise,
   input  logic  clr,
   output logic  req
);

   logic req_d;

   always_comb begin
      unique case (trig)
         TRIG_RISE:  req_d = req | rise;
         TRIG_LEVEL: req_d = lvl;
         default:    req_d = 1'b0;
      endcase
      if (clr) begin
         req_d = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req <= 1'b0;
      end else begin
         req <= req_d;
      end
   end

endmodule

// File: rtl/irq_capture.sv
module irq_capture
   import irq_cap_pkg::*;
#(
   parameter int NUM_CH      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] irq_async_i,
   input  logic [NUM_CH-1:0] trig_edge_i,
   input  logic [NUM_CH-1:0] ack_clr_i,
   input  logic              glob_en_i,
   input  logic              dbg_ack_async_i,
   output logic [NUM_CH-1:0] irq_req_o,
   output logic              dbg_ack_sync_o,
   output logic              glob_en_eff_o
);

   if (NUM_CH < 1 || NUM_CH > CH_MAX) begin : g_bad_ch
      $error("irq_capture: NUM_CH out of range");
   end
   if (SYNC_STAGES < SYNC_MIN || SYNC_STAGES > SYNC_MAX) begin : g_bad_sync
      $error("irq_capture: SYNC_STAGES out of range");
   end

   logic [NUM_CH-1:0] irq_sync;
   logic [NUM_CH-1:0] irq_prev;
   logic [NUM_CH-1:0] irq_rise;

   irq_sync_chain #(
      .WIDTH   (NUM_CH),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ('0)
   ) u_irq_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (irq_async_i),
      .q_sync  (irq_sync)
   );

   irq_sync_chain #(
      .WIDTH   (1),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
   ) u_dbg_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (dbg_ack_async_i),
      .q_sync  (dbg_ack_sync_o)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      irq_edge_det u_edge (
         .clk   (clk),
         .rst_n (rst_n),
         .lvl   (irq_sync[ch]),
         .prev  (irq_prev[ch]),
         .rise  (irq_rise[ch])
      );

      irq_req_bit u_req (
         .clk   (clk),
         .rst_n (rst_n),
         .trig  (trig_e'(trig_edge_i[ch])),
         .lvl   (irq_sync[ch]),
         .rise  (irq_rise[ch]),
         .clr   (ack_clr_i[ch]),
         .req   (irq_req_o[ch])
      );
   end

   // debug acknowledge masks the controller's global enable
   assign glob_en_eff_o = glob_en_i & ~dbg_ack_sync_o;

endmodule

// File: rtl/irq_capture_chk.sv
module irq_capture_chk #(
   parameter int NUM_CH      = 8,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] mode_edge,
   input logic [NUM_CH-1:0] clr,
   input logic [NUM_CH-1:0] req,
   input logic [NUM_CH-1:0] sync_lvl,
   input logic [NUM_CH-1:0] sync_prev,
   input logic              dbg_raw,
   input logic              dbg_sync
);

   // edges seen with reset released, saturating
   logic [2:0] live_cyc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_cyc <= '0;
      end else if (live_cyc != 3'd7) begin
         live_cyc <= live_cyc + 3'd1;
      end
   end

   a_r2_dbg_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(live_cyc) >= SYNC_STAGES) |-> (dbg_sync == $past(dbg_raw, SYNC_STAGES)));

   a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (live_cyc != 3'd0) |-> ((req & $past(clr)) == '0));

   a_r4_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (live_cyc != 3'd0) |-> (($past(mode_edge & req & ~clr) & ~req) == '0));

   a_r3_edge_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (live_cyc != 3'd0) |->
      (($past(mode_edge & ~req) & req & ~$past(sync_lvl & ~sync_prev)) == '0));

   a_r6_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (live_cyc != 3'd0) |-> ((~$past(mode_edge) & (req ^ $past(sync_lvl & ~clr))) == '0));

   a_r8_reset_state: assert property (@(posedge clk)
      !rst_n |=> ((req == '0) && !dbg_sync));

endmodule

bind irq_capture irq_capture_chk #(
   .NUM_CH      (NUM_CH),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_edge (trig_edge_i),
   .clr       (ack_clr_i),
   .req       (irq_req_o),
   .sync_lvl  (irq_sync),
   .sync_prev (irq_prev),
   .dbg_raw   (dbg_ack_async_i),
   .dbg_sync  (dbg_ack_sync_o)
);

// File: tb/sim_irq_capture.sv
module sim_irq_capture;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] irq = '0;
   logic [N-1:0] mode = '0;
   logic [N-1:0] clr = '0;
   logic         gen = 1'b0;
   logic         dbg = 1'b0;
   logic [N-1:0] req;
   logic         dbg_s;
   logic         en_eff;

   always #4 clk = ~clk;   // 125 MHz

   irq_capture #(
      .NUM_CH      (N),
      .SYNC_STAGES (2)
   ) u0 (
      .clk             (clk),
      .rst_n           (rst_n),
      .irq_async_i     (irq),
      .trig_edge_i     (mode),
      .ack_clr_i       (clr),
      .glob_en_i       (gen),
      .dbg_ack_async_i (dbg),
      .irq_req_o       (req),
      .dbg_ack_sync_o  (dbg_s),
      .glob_en_eff_o   (en_eff)
   );

   int checks = 0;
   int errors = 0;

   // cycle model built from the requirements
   logic [N-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_req = '0;
   logic         m_d1 = 1'b0, m_d2 = 1'b0;
   logic [15:0]  lf = 16'hACE1;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step();
      logic [N-1:0] nreq;
      for (int i = 0; i < N; i++) begin
         if (clr[i])       nreq[i] = 1'b0;
         else if (mode[i]) nreq[i] = m_req[i] | (m_s2[i] & ~m_prev[i]);
         else              nreq[i] = m_s2[i];
      end
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_prev = '0; m_req = '0; m_d1 = 1'b0; m_d2 = 1'b0;
      end else begin
         m_req = nreq; m_prev = m_s2; m_s2 = m_s1; m_s1 = irq;
         m_d2 = m_d1; m_d1 = dbg;
      end
      @(posedge clk);
      #1;
   endtask

   task automatic cmp_all();
      for (int i = 0; i < N; i++) begin
         chk(mode[i] ? "R4 edge channel" : "R6 level channel", 32'(req[i]), 32'(m_req[i]));
      end
      chk("R2", 32'(dbg_s), 32'(m_d2));
      chk("R7", 32'(en_eff), 32'(gen & ~m_d2));
   endtask

   task automatic adv_lf();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
   endtask

   initial begin : p_watchdog
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : p_main
      irq = '1; dbg = 1'b1;          // raw lines high during reset
      repeat (3) step();
      chk("R8 req after reset", 32'(req), 32'h0);
      chk("R8 dbg after reset", 32'(dbg_s), 32'h0);
      irq = '0; dbg = 1'b0;
      rst_n = 1'b1;
      repeat (3) step();
      chk("R8 idle", 32'(req), 32'h0);

      // R1 latency, edge mode channel 0
      mode = 4'b0001;
      irq[0] = 1'b1;
      step(); chk("R1 edge 1", 32'(req[0]), 32'h0);
      step(); chk("R1 edge 2", 32'(req[0]), 32'h0);
      step(); chk("R1 edge 3", 32'(req[0]), 32'h1);
      // R4 sticky after line drops
      irq[0] = 1'b0;
      repeat (4) step();
      chk("R4 holds", 32'(req[0]), 32'h1);
      // R5 clear
      clr[0] = 1'b1; step(); clr[0] = 1'b0;
      chk("R5 clear", 32'(req[0]), 32'h0);
      // R3: new edge sets, held-high line does not re-arm after clear
      irq[0] = 1'b1;
      repeat (4) step();
      chk("R3 new edge", 32'(req[0]), 32'h1);
      clr[0] = 1'b1; step(); clr[0] = 1'b0;
      repeat (4) step();
      chk("R3 held high no re-set", 32'(req[0]), 32'h0);

      // R6 level mode channel 1, R5 over high level
      mode = 4'b0001;
      irq[1] = 1'b1;
      repeat (3) step();
      chk("R6 level up", 32'(req[1]), 32'h1);
      clr[1] = 1'b1; step(); clr[1] = 1'b0;
      chk("R5 over level", 32'(req[1]), 32'h0);
      step();
      chk("R6 level back", 32'(req[1]), 32'h1);
      irq[1] = 1'b0;
      repeat (2) step();
      chk("R6 level lag", 32'(req[1]), 32'h1);
      step();
      chk("R6 level down", 32'(req[1]), 32'h0);

      // R2 debug latency, R7 masking
      gen = 1'b1;
      dbg = 1'b1;
      step(); chk("R2 dbg edge 1", 32'(dbg_s), 32'h0);
      chk("R7 en before mask", 32'(en_eff), 32'h1);
      step(); chk("R2 dbg edge 2", 32'(dbg_s), 32'h1);
      chk("R7 masked", 32'(en_eff), 32'h0);
      dbg = 1'b0;
      repeat (2) step();
      chk("R7 unmasked", 32'(en_eff), 32'h1);
      irq = '0;
      repeat (4) step();
      cmp_all();

      // sweep every per-channel mode mix
      for (int m = 0; m < (1 << N); m++) begin
         mode = N'(m);
         for (int c = 0; c < 48; c++) begin
            adv_lf();
            if (lf[0]) irq = lf[N:1];
            clr = lf[N+4:5] & lf[N+8:9] & lf[N+10:11];
            if (lf[15] & lf[14]) dbg = ~dbg;
            gen = lf[13] | lf[12];
            step();
            cmp_all();
         end
         clr = '1; step(); clr = '0; cmp_all();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule